// File: doc/BRIEF.md
# Eight-State Asynchronous-Style Bus Cycle Sequencer

This block turns one request from an internal master into a single external bus transfer of the classic strobe-and-acknowledge kind. The master offers a transfer with a valid/ready handshake: `req_valid` carries a 24-bit address, a write flag and 8 bits of write data. The block accepts it only while `req_ready` is high, which is only when it is idle. Holding `req_valid` high while `req_ready` is low is the master's form of back-pressure. The request is neither lost nor taken early, and it is accepted on the first idle edge. Completion is a one-cycle `rsp_valid` pulse that carries read data. The response has no ready signal, so the master must be able to take it in any cycle.

On the bus side each transfer steps through eight states, S0 to S7, one state per clock. The direction line is set first. The address follows one state later. The address strobe and the data strobe then fall together. The sequencer waits in S4 until the slave pulls its active-low acknowledge down, so a slow slave stretches the cycle by whole clocks. The pads are split into `bus_data_out`, `bus_data_oe` and `bus_data_in`, so that the tri-state driver sits in the pad ring. An optional synchronizer on the acknowledge input, `ACK_SYNC` stages deep and 0 by default, suits slaves that run on another clock.

Top module: `mbus_seq`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge, `bus_as_n`, `bus_ds_n` and `bus_rw` are 1, `bus_data_oe` and `rsp_valid` are 0, `bus_addr` is 0 and `req_ready` is 1.
- R2: The cycle after an accepting edge is S0. In S0, `bus_rw` equals the inverse of the write flag (1 = read), both strobes are still 1 and `bus_addr` is still 0.
- R3: From S1 through S7, `bus_addr` carries the accepted address and does not change while `bus_as_n` is 0.
- R4: `bus_as_n` and `bus_ds_n` are always equal. Both fall together on entry to S2 and both are back at 1 in S7.
- R5: No bus output differs between S2 and S3.
- R6: With `ACK_SYNC` = 0, the sequencer stays in S4 while `bus_dtack_n` is 1 at the edge, and it moves to S5 on the first edge at which `bus_dtack_n` is 0.
- R7: `bus_data_oe` is 1 exactly when a write transfer has its strobes low (S2 to S6), and `bus_data_out` then carries the accepted write data. For reads `bus_data_oe` stays 0.
- R8: For a read, `bus_data_in` is captured at the edge that ends S6. It appears on `rsp_rdata` with `rsp_valid` high for exactly one cycle, in S7.
- R9: `req_ready` is 0 from S0 through S7. A `req_valid` raised while busy changes neither the running transfer's address, direction or timing, nor does it start a transfer of its own.
- R10: Counting S0 as cycle 0, `rsp_valid` is high in cycle 7 + W, where W is the number of extra cycles spent in S4.
- R11: A synchronous reset raised in the middle of a transfer returns the block to idle at that edge with the R1 values, and no `rsp_valid` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Master offers a transfer |
| req_ready | output | 1 | Block is idle and will accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Transfer address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid with `rsp_valid` on reads |
| bus_addr | output | 24 | External address bus |
| bus_data_out | output | 8 | Data driven toward the pad |
| bus_data_oe | output | 1 | Pad output enable |
| bus_data_in | input | 8 | Data returned from the pad |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_ds_n | output | 1 | Data strobe, active low |
| bus_rw | output | 1 | Direction, 1 = read |
| bus_dtack_n | input | 1 | Slave acknowledge, active low |

## Verification
The acknowledge can meet the sequencer on the very edge that ends S4's first cycle. In that case the wait stretching and the normal advance fall in the same cycle. The bench provokes this with a slave whose delay lands its acknowledge in S3 or S4, and with slaves that answer earlier and later. The scoreboard judges each case by the exact cycle of `rsp_valid` against 7 + W. A second pair of events is a reset that falls while S4 is still waiting on a slow acknowledge. That case is judged by idle outputs on the next cycle and by the absence of any completion pulse.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_S0, ST_S1, ST_S2, ST_S3,
    ST_S4, ST_S5, ST_S6, ST_S7
  } seq_state_t;
endpackage

// File: rtl/mbus_ack_sync.sv
module mbus_ack_sync #(
  parameter int STAGES = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic dtack_n,
  output logic ack
);
  generate
    if (STAGES == 0) begin : g_direct
      assign ack = ~dtack_n;
    end else begin : g_sync
      logic [STAGES-1:0] chain;
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
          always_ff @(posedge clk) begin
            if (rst) chain[i] <= 1'b1;
            else     chain[i] <= dtack_n;
          end
        end else begin : g_next
          always_ff @(posedge clk) begin
            if (rst) chain[i] <= 1'b1;
            else     chain[i] <= chain[i-1];
          end
        end
      end
      assign ack = ~chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/mbus_fsm.sv
module mbus_fsm
  import mbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       ack,
  output seq_state_t st,
  output logic       load,
  output logic       drive_addr,
  output logic       strobe,
  output logic       capture,
  output logic       done
);
  seq_state_t st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (start) st_nx = ST_S0;
      ST_S0:   st_nx = ST_S1;
      ST_S1:   st_nx = ST_S2;
      ST_S2:   st_nx = ST_S3;
      ST_S3:   st_nx = ST_S4;
      ST_S4:   if (ack) st_nx = ST_S5;
      ST_S5:   st_nx = ST_S6;
      ST_S6:   st_nx = ST_S7;
      ST_S7:   st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nx;
  end

  assign load       = (st == ST_IDLE) && start;
  assign drive_addr = (st != ST_IDLE) && (st != ST_S0);
  assign strobe     = (st == ST_S2) || (st == ST_S3) || (st == ST_S4) ||
                      (st == ST_S5) || (st == ST_S6);
  assign capture    = (st == ST_S6);
  assign done       = (st == ST_S7);
endmodule

// File: rtl/mbus_datapath.sv
module mbus_datapath #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              busy,
  input  logic              drive_addr,
  input  logic              strobe,
  input  logic              capture,
  input  logic              in_write,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [DATA_W-1:0] pad_in,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] pad_out,
  output logic              pad_oe,
  output logic              rw_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
    end else if (load) begin
      addr_q  <= in_addr;
      wdata_q <= in_wdata;
      wr_q    <= in_write;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  rdata_q <= '0;
    else if (capture && !wr_q) rdata_q <= pad_in;
  end

  assign addr_o  = drive_addr ? addr_q : '0;
  assign pad_oe  = strobe && wr_q;
  assign pad_out = pad_oe ? wdata_q : '0;
  assign rw_o    = busy ? ~wr_q : 1'b1;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 8,
  parameter int ACK_SYNC = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data_out,
  output logic              bus_data_oe,
  input  logic [DATA_W-1:0] bus_data_in,
  output logic              bus_as_n,
  output logic              bus_ds_n,
  output logic              bus_rw,
  input  logic              bus_dtack_n
);
  seq_state_t st;
  logic ack, load, drive_addr, strobe, capture, done, busy;

  mbus_ack_sync #(.STAGES(ACK_SYNC)) u_sync (
    .clk(clk), .rst(rst), .dtack_n(bus_dtack_n), .ack(ack)
  );

  mbus_fsm u_fsm (
    .clk(clk), .rst(rst), .start(req_valid), .ack(ack), .st(st),
    .load(load), .drive_addr(drive_addr), .strobe(strobe),
    .capture(capture), .done(done)
  );

  assign busy = (st != ST_IDLE);

  mbus_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .load(load), .busy(busy),
    .drive_addr(drive_addr), .strobe(strobe), .capture(capture),
    .in_write(req_write), .in_addr(req_addr), .in_wdata(req_wdata),
    .pad_in(bus_data_in), .addr_o(bus_addr), .pad_out(bus_data_out),
    .pad_oe(bus_data_oe), .rw_o(bus_rw), .rdata_o(rsp_rdata)
  );

  assign req_ready = ~busy;
  assign rsp_valid = done;
  assign bus_as_n  = ~strobe;
  assign bus_ds_n  = ~(strobe && (st != ST_IDLE));
endmodule

// File: rtl/mbus_seq_chk.sv
module mbus_seq_chk
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_data_oe,
  input logic              bus_as_n,
  input logic              bus_ds_n,
  input logic              bus_rw,
  input logic              ack,
  input seq_state_t        st
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (bus_as_n && bus_ds_n && bus_rw && req_ready && !rsp_valid && !bus_data_oe));

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !bus_as_n |-> $stable(bus_addr));

  assert_strobe_pair_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_as_n) |-> $fell(bus_ds_n));

  assert_wait_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_S4 && !ack) |=> (st == ST_S4));

  assert_oe_write_R7: assert property (@(posedge clk) disable iff (rst)
    bus_data_oe |-> (!bus_rw && !bus_as_n));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_busy_block_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind mbus_seq mbus_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .bus_addr(bus_addr), .bus_data_oe(bus_data_oe),
  .bus_as_n(bus_as_n), .bus_ds_n(bus_ds_n), .bus_rw(bus_rw),
  .ack(ack), .st(st)
);

// File: tb/mbus_seq_tb.sv
module mbus_seq_tb;
  typedef struct packed {
    logic        w;
    logic [23:0] a;
    logic [7:0]  d;
    logic [7:0]  wt;
  } xfer_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, bus_data_oe, bus_as_n, bus_ds_n, bus_rw;
  logic [7:0]  rsp_rdata, bus_data_out, bus_data_in;
  logic [23:0] bus_addr;
  logic bus_dtack_n = 1'b1;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int slave_delay = 0, scnt = 0;
  logic [7:0] cap = '0;

  always #2 clk = ~clk;

  mbus_seq u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
    .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe),
    .bus_data_in(bus_data_in), .bus_as_n(bus_as_n), .bus_ds_n(bus_ds_n),
    .bus_rw(bus_rw), .bus_dtack_n(bus_dtack_n)
  );

  function automatic logic [7:0] mem_val(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  // slave model: answers reads from a computed memory, acknowledges after slave_delay strobe cycles
  assign bus_data_in = (!bus_as_n && bus_rw) ? mem_val(bus_addr) : 8'h00;

  always @(negedge clk) begin
    if (rst || bus_as_n) begin
      scnt = 0;
      bus_dtack_n = 1'b1;
    end else begin
      scnt = scnt + 1;
      bus_dtack_n = !(scnt >= slave_delay);
      if (!bus_rw && !bus_dtack_n) cap = bus_data_out;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      chk(1'b0, "WATCHDOG", "run hung", cyc, 50000);
      report();
    end
  end

  // scoreboard monitor
  xfer_t exp_q[$];
  xfer_t cur;
  bit active = 0, post = 0, done_seen = 0;
  int idx = 0;
  logic [35:0] snap;

  always @(negedge clk) begin
    if (rst) begin
      active = 0;
      post = 0;
      exp_q.delete();
    end else begin
      if (post) begin
        chk(!rsp_valid && req_ready, "R8", "pulse not single / not idle after done",
            {rsp_valid, req_ready}, 2'b01);
        post = 0;
      end
      if (!active && !req_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R9", "unexpected transfer start", 1, 0);
        else begin
          cur = exp_q.pop_front();
          active = 1;
          idx = 0;
        end
      end
      if (active) begin
        if (idx == 0) begin
          chk(bus_rw == !cur.w, "R2", "rw in S0", bus_rw, !cur.w);
          chk(bus_as_n && bus_ds_n, "R2", "strobes in S0", {bus_as_n, bus_ds_n}, 2'b11);
          chk(bus_addr == 24'h0, "R2", "addr in S0", bus_addr, 0);
        end else begin
          chk(bus_addr == cur.a, "R3", "addr", bus_addr, cur.a);
        end
        chk(bus_as_n == bus_ds_n, "R4", "strobe pair", {bus_as_n, bus_ds_n}, {bus_as_n, bus_as_n});
        chk(bus_data_oe == (cur.w && !bus_as_n), "R7", "data enable", bus_data_oe, cur.w && !bus_as_n);
        if (bus_data_oe) chk(bus_data_out == cur.d, "R7", "write data", bus_data_out, cur.d);
        if (idx == 2) begin
          chk(!bus_as_n && !bus_ds_n, "R4", "strobes in S2", {bus_as_n, bus_ds_n}, 0);
          snap = {bus_addr, bus_as_n, bus_ds_n, bus_rw, bus_data_oe, bus_data_out[3:0]} ^ {28'h0, bus_data_out[7:4], 4'h0};
        end
        if (idx == 3)
          chk(snap == ({bus_addr, bus_as_n, bus_ds_n, bus_rw, bus_data_oe, bus_data_out[3:0]} ^ {28'h0, bus_data_out[7:4], 4'h0}),
              "R5", "S3 outputs moved", 0, 0);
        if (rsp_valid) begin
          if (cur.wt != 0) chk(idx == 7 + int'(cur.wt), "R6", "stretched done cycle", idx, 7 + int'(cur.wt));
          else             chk(idx == 7, "R10", "done cycle", idx, 7);
          chk(bus_as_n && bus_ds_n, "R4", "strobes released in S7", {bus_as_n, bus_ds_n}, 2'b11);
          if (!cur.w) chk(rsp_rdata == mem_val(cur.a), "R8", "read data", rsp_rdata, mem_val(cur.a));
          else        chk(cap == cur.d, "R7", "slave captured write", cap, cur.d);
          active = 0;
          post = 1;
          done_seen = 1;
        end
        idx++;
      end
    end
  end

  task automatic wait_neg();
    @(negedge clk);
    #1;
  endtask

  task automatic xfer(input bit w, input logic [23:0] a, input logic [7:0] d,
                      input int dly, input bit poke);
    xfer_t e;
    wait_neg();
    while (!req_ready) wait_neg();
    slave_delay = dly;
    e.w = w; e.a = a; e.d = d;
    e.wt = (dly > 3) ? 8'(dly - 3) : 8'd0;
    exp_q.push_back(e);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    wait_neg();
    req_valid = 1'b0;
    if (poke) begin
      wait_neg();
      wait_neg();
      req_valid = 1'b1; req_write = !w; req_addr = ~a; req_wdata = ~d;
      chk(!req_ready, "R9", "ready while busy", req_ready, 0);
      wait_neg();
      wait_neg();
      req_valid = 1'b0;
    end
    while (!done_seen) wait_neg();
    done_seen = 0;
  endtask

  initial begin
    xfer_t e;
    repeat (3) wait_neg();
    // R1: reset state
    chk(bus_as_n && bus_ds_n && bus_rw, "R1", "strobes/rw in reset", {bus_as_n, bus_ds_n, bus_rw}, 3'b111);
    chk(req_ready && !rsp_valid && !bus_data_oe, "R1", "handshake in reset",
        {req_ready, rsp_valid, bus_data_oe}, 3'b100);
    chk(bus_addr == 0, "R1", "addr in reset", bus_addr, 0);
    rst = 1'b0;

    xfer(1'b0, 24'h123456, 8'h00, 1, 1'b0);   // read, early acknowledge (R10)
    xfer(1'b1, 24'hABCDEF, 8'hC3, 3, 1'b0);   // write, acknowledge lands in S4 (R6 boundary)
    xfer(1'b0, 24'h00F00D, 8'h00, 6, 1'b0);   // read, 3 wait cycles (R6)
    xfer(1'b1, 24'h000000, 8'hFF, 0, 1'b0);   // write, acknowledge at once
    xfer(1'b0, 24'hFFFFFF, 8'h00, 2, 1'b0);   // read, all-ones address
    xfer(1'b1, 24'h800001, 8'h5A, 8, 1'b0);   // write, 5 wait cycles
    xfer(1'b0, 24'h4A4A4A, 8'h00, 4, 1'b1);   // R9: request raised while busy
    xfer(1'b1, 24'h13579B, 8'h81, 1, 1'b1);   // R9 on a write

    // R11: reset while waiting in S4
    wait_neg();
    slave_delay = 20;
    e.w = 1'b1; e.a = 24'h777777; e.d = 8'h99; e.wt = 8'd17;
    exp_q.push_back(e);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 24'h777777; req_wdata = 8'h99;
    wait_neg();
    req_valid = 1'b0;
    repeat (5) wait_neg();
    rst = 1'b1;
    wait_neg();
    rst = 1'b0;
    chk(bus_as_n && bus_ds_n && bus_rw && !bus_data_oe, "R11", "bus idle after abort",
        {bus_as_n, bus_ds_n, bus_rw, bus_data_oe}, 4'b1110);
    chk(req_ready && !rsp_valid, "R11", "handshake after abort", {req_ready, rsp_valid}, 2'b10);
    repeat (12) begin
      wait_neg();
      chk(!rsp_valid && bus_as_n, "R11", "no completion after abort", {rsp_valid, bus_as_n}, 2'b01);
    end

    xfer(1'b0, 24'h2468AC, 8'h00, 5, 1'b0);   // recovery read
    repeat (3) wait_neg();
    report();
  end
endmodule